// File: doc/BRIEF.md
# Supervisory Reset Stretcher

This block generates the system reset for a supervisor. Three causes can request a reset. The first is a supply-good flag that an external comparator drives. The second is an active-low manual reset line from a push-button. The third is a one-cycle request from a companion watchdog. The block drives one reset output that is active high and one that is active low. Reset stays on while any cause is present. After the last cause goes away, reset stays on for one fixed hold-off period, and only then does it release. All delays are counted in cycles of `clk`, so a simulation can use short values.

The manual line is first brought into the clock domain by a two-flop synchronizer. It then passes through a qualifier: a low level counts only after it has lasted a minimum number of cycles, so short bounces and glitches are filtered out. The qualifier counter stops at its limit and does not wrap. A single shared timer measures the hold-off period. Any cause that shows up while the timer runs sends the block back to the asserted state, and the timer starts from zero again.

The sequencer has three states, each named below. `ST_CAUSE` means a cause is present and the timer is held at zero. `ST_HOLD` means no cause is present and the timer is counting. `ST_RUN` means reset is released. The transitions are:
- *clear*: from `ST_CAUSE` to `ST_HOLD`, taken when no cause is sampled.
- *rearm*: from `ST_HOLD` to `ST_CAUSE`, taken when a cause is sampled.
- *expire*: from `ST_HOLD` to `ST_RUN`, taken when the timer has reached its last count with no cause.
- *trip*: from `ST_RUN` to `ST_CAUSE`, taken when a cause is sampled.

`por_n` puts the block in `ST_CAUSE` with both outputs asserted.

Top module: `rst_stretch_top`

## Requirements
- R1: `rst_out_n` is always the complement of `rst_out`. Reset is active when `rst_out`=1 and `rst_out_n`=0.
- R2: While `por_n` is low, and after it rises, reset is active. It releases on the (HOLD_CYCLES+1)-th rising edge, counting the first edge at which `supply_ok` is sampled 1 as edge 1, provided `supply_ok` has stayed 1 throughout.
- R3: When `supply_ok` is sampled 0, reset is active after that same edge. The hold-off timer restarts from zero, so after `supply_ok` returns to 1, release again takes HOLD_CYCLES+1 edges, counted as in R2.
- R4: A low pulse on `mr_n` that spans fewer than MR_QUAL_CYCLES sampling edges leaves reset released.
- R5: A low pulse on `mr_n` that spans MR_QUAL_CYCLES or more sampling edges asserts reset. When `mr_n` stays low, the assertion appears on edge MR_QUAL_CYCLES+3, counting the first edge at which `mr_n` is sampled 0 as edge 1.
- R6: After a qualified manual reset, reset releases on edge HOLD_CYCLES+4, counting the first edge at which `mr_n` is sampled 1 as edge 1.
- R7: When `wd_req` is sampled 1, reset is active after that edge. For a one-cycle request, reset releases on edge HOLD_CYCLES+2, counting the request edge as edge 1.
- R8: A cause that appears during the hold-off period restarts the full period, and reset never shows a gap in between.
- R9: The manual qualifier saturates. A manual low held for many times MR_QUAL_CYCLES keeps reset active for its whole length, and the release timing of R6 still applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Supply good flag from the comparator, synchronous |
| mr_n | input | 1 | Manual reset, active low, asynchronous |
| wd_req | input | 1 | Watchdog reset request, synchronous, one cycle |
| rst_out | output | 1 | System reset, active high |
| rst_out_n | output | 1 | System reset, active low |

## Verification
The bench sweeps the length of a manual low pulse across the qualification threshold. A qualifier that is off by one would either trip on the longest pulse that should be ignored or miss the shortest pulse that should count. A second sweep re-arms the design with a watchdog request at every offset inside the hold-off window. A third sweep drops the supply at every such offset. A timer that did not restart, or that released early, would show up as a release count shorter than the full period. A manual hold many times the qualification length checks the saturation behaviour, because a counter that wrapped would release reset while the button is still held.

// File: rtl/rst_stretch_pkg.sv
package rst_stretch_pkg;

    typedef enum logic [1:0] {
        ST_CAUSE = 2'd0,
        ST_HOLD  = 2'd1,
        ST_RUN   = 2'd2
    } stretch_state_e;

endpackage

// File: rtl/rst_sync_chain.sv
module rst_sync_chain #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain_q[0] <= RESET_VAL;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain_q[i] <= RESET_VAL;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/mr_qualifier.sv
module mr_qualifier #(
    parameter int QUAL_CYCLES = 50
) (
    input  logic clk,
    input  logic por_n,
    input  logic btn_low,
    output logic qualified
);
    localparam int QW = $clog2(QUAL_CYCLES + 1);
    localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

    logic [QW-1:0] low_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_cnt <= '0;
        end else if (!btn_low) begin
            low_cnt <= '0;
        end else if (low_cnt != QMAX) begin
            low_cnt <= low_cnt + QW'(1);
        end
    end

    assign qualified = (low_cnt == QMAX);
endmodule

// File: rtl/hold_sequencer.sv
module hold_sequencer
    import rst_stretch_pkg::*;
#(
    parameter int HOLD_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic cause,
    output logic rst_hi,
    output logic rst_lo
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    stretch_state_e state_q, state_nxt;
    logic [CW-1:0]  cnt_q, cnt_nxt;

    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        unique case (state_q)
            ST_CAUSE: begin
                cnt_nxt = '0;
                if (!cause) state_nxt = ST_HOLD;        // clear
            end
            ST_HOLD: begin
                if (cause) begin
                    state_nxt = ST_CAUSE;               // rearm
                    cnt_nxt   = '0;
                end else if (cnt_q == LAST) begin
                    state_nxt = ST_RUN;                 // expire
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt_q + CW'(1);
                end
            end
            ST_RUN: begin
                cnt_nxt = '0;
                if (cause) state_nxt = ST_CAUSE;        // trip
            end
            default: begin
                state_nxt = ST_CAUSE;
                cnt_nxt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_CAUSE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rst_hi <= 1'b1;
            rst_lo <= 1'b0;
        end else begin
            rst_hi <= (state_nxt != ST_RUN);
            rst_lo <= (state_nxt == ST_RUN);
        end
    end
endmodule

// File: rtl/rst_stretch_top.sv
module rst_stretch_top #(
    parameter int HOLD_CYCLES    = 12_500_000,
    parameter int MR_QUAL_CYCLES = 50,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok,
    input  logic mr_n,
    input  logic wd_req,
    output logic rst_out,
    output logic rst_out_n
);
    logic mr_n_sync;
    logic mr_active;
    logic any_cause;

    rst_sync_chain #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_mr_sync (
        .clk  (clk),
        .por_n(por_n),
        .d_in (mr_n),
        .q_out(mr_n_sync)
    );

    mr_qualifier #(
        .QUAL_CYCLES(MR_QUAL_CYCLES)
    ) u_mr_qual (
        .clk      (clk),
        .por_n    (por_n),
        .btn_low  (!mr_n_sync),
        .qualified(mr_active)
    );

    assign any_cause = !supply_ok || mr_active || wd_req;

    hold_sequencer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_seq (
        .clk   (clk),
        .por_n (por_n),
        .cause (any_cause),
        .rst_hi(rst_out),
        .rst_lo(rst_out_n)
    );
endmodule

// File: rtl/rst_stretch_chk.sv
module rst_stretch_chk #(
    parameter int HOLD_CYCLES = 16
) (
    input logic clk,
    input logic por_n,
    input logic supply_ok,
    input logic wd_req,
    input logic rst_out,
    input logic rst_out_n
);
    int quiet_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                    quiet_cnt <= 0;
        else if (!supply_ok || wd_req) quiet_cnt <= 0;
        else if (quiet_cnt < HOLD_CYCLES + 4) quiet_cnt <= quiet_cnt + 1;
    end

    p_complement_r1: assert property (@(posedge clk) disable iff (!por_n)
        rst_out_n == !rst_out);

    p_supply_drop_r3: assert property (@(posedge clk) disable iff (!por_n)
        !supply_ok |=> rst_out);

    p_wd_assert_r7: assert property (@(posedge clk) disable iff (!por_n)
        wd_req |=> rst_out);

    p_release_quiet_r8: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_out) |-> ($past(supply_ok) && !$past(wd_req)));

    p_full_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_out) |-> (quiet_cnt >= HOLD_CYCLES));
endmodule

bind rst_stretch_top rst_stretch_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .supply_ok(supply_ok),
    .wd_req   (wd_req),
    .rst_out  (rst_out),
    .rst_out_n(rst_out_n)
);

// File: tb/rst_stretch_top_tb.sv
module rst_stretch_top_tb;
    localparam int HOLD = 16;
    localparam int QUAL = 4;

    logic clk = 1'b0;
    logic por_n, supply_ok, mr_n, wd_req;
    logic rst_out, rst_out_n;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rst_stretch_top #(
        .HOLD_CYCLES   (HOLD),
        .MR_QUAL_CYCLES(QUAL),
        .SYNC_STAGES   (2)
    ) u_dut (
        .clk      (clk),
        .por_n    (por_n),
        .supply_ok(supply_ok),
        .mr_n     (mr_n),
        .wd_req   (wd_req),
        .rst_out  (rst_out),
        .rst_out_n(rst_out_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // counts posedges from the next edge (edge 1) until rst_out is seen high
    task automatic count_rise(input int limit, output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!rst_out && n < limit);
    endtask

    // counts posedges from the next edge (edge 1) until rst_out falls after being high
    task automatic count_fall(input int limit, output int n);
        bit seen;
        seen = rst_out;
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
            if (rst_out) seen = 1'b1;
        end while (!(seen && !rst_out) && n < limit);
    endtask

    task automatic settle();
        for (int i = 0; i < 4 * HOLD && rst_out; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wd_pulse();
        wd_req = 1'b1;
        @(negedge clk);
        wd_req = 1'b0;
    endtask

    initial begin
        int n;
        bit hit;
        por_n = 1'b0; supply_ok = 1'b0; mr_n = 1'b1; wd_req = 1'b0;
        repeat (3) @(negedge clk);
        check(rst_out == 1'b1 && rst_out_n == 1'b0, "R1 reset state", rst_out, 1);
        por_n = 1'b1;
        repeat (5) @(negedge clk);
        check(rst_out == 1'b1, "R2 held while supply low", rst_out, 1);
        supply_ok = 1'b1;
        count_fall(4 * HOLD, n);
        check(n == HOLD + 1, "R2 power-up release", n, HOLD + 1);
        check(rst_out_n == 1'b1, "R1 complement after release", rst_out_n, 1);

        // R3 supply drop while running
        repeat (3) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        check(rst_out == 1'b1, "R3 drop asserts", rst_out, 1);
        supply_ok = 1'b1;
        count_fall(4 * HOLD, n);
        check(n == HOLD + 1, "R3 release after drop", n, HOLD + 1);

        // R7 watchdog request
        settle();
        wd_pulse();
        check(rst_out == 1'b1 && rst_out_n == 1'b0, "R7 request asserts", rst_out, 1);
        count_fall(4 * HOLD, n);
        check(n == HOLD + 1, "R7 release after request", n + 1, HOLD + 2);

        // R4/R5/R6 manual pulse length sweep
        for (int len = 1; len <= QUAL + 4; len++) begin
            settle();
            mr_n = 1'b0;
            repeat (len) @(negedge clk);
            mr_n = 1'b1;
            if (len < QUAL) begin
                hit = 1'b0;
                for (int i = 0; i < HOLD + QUAL + 6; i++) begin
                    @(negedge clk);
                    if (rst_out) hit = 1'b1;
                end
                check(!hit, "R4 short manual pulse ignored", hit, 0);
            end else begin
                count_fall(4 * HOLD, n);
                check(n == HOLD + 4, "R6 manual release timing", n, HOLD + 4);
            end
        end

        // R5 assertion latency with a held button
        settle();
        mr_n = 1'b0;
        count_rise(4 * QUAL + 8, n);
        check(n == QUAL + 3, "R5 manual assert latency", n, QUAL + 3);

        // R9 long hold keeps reset, release timing intact
        hit = 1'b0;
        for (int i = 0; i < 12 * QUAL + 3 * HOLD; i++) begin
            @(negedge clk);
            if (!rst_out) hit = 1'b1;
        end
        check(!hit, "R9 saturated hold keeps reset", hit, 0);
        mr_n = 1'b1;
        count_fall(4 * HOLD, n);
        check(n == HOLD + 4, "R9 release after long hold", n, HOLD + 4);

        // R8 watchdog re-arm at every offset inside the hold window
        for (int off = 0; off < HOLD; off++) begin
            settle();
            wd_pulse();
            repeat (off) @(negedge clk);
            check(rst_out == 1'b1, "R8 no gap before re-arm", rst_out, 1);
            wd_pulse();
            count_fall(4 * HOLD, n);
            check(n == HOLD + 1, "R8 re-arm restarts hold", n + 1, HOLD + 2);
        end

        // R3 supply drop at every offset inside the hold window
        for (int off = 0; off < HOLD; off++) begin
            settle();
            wd_pulse();
            repeat (off) @(negedge clk);
            supply_ok = 1'b0;
            @(negedge clk);
            check(rst_out == 1'b1, "R3 drop in hold asserts", rst_out, 1);
            supply_ok = 1'b1;
            count_fall(4 * HOLD, n);
            check(n == HOLD + 1, "R3 drop in hold restarts timer", n, HOLD + 1);
        end

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule